// File: doc/BRIEF.md
# Cache Coherence Directory Controller

This block is the central bookkeeping point for cache coherence among eight processors that each hold a private cache in front of one shared memory. For every memory block it records which processors may hold a copy. When a processor asks to write, the block tells every other recorded holder to drop its copy. When a processor asks to read a block that another processor has modified, the block first asks that owner to write the data back. Caches, data movement and the interconnect lie outside this block. Only the sharer bookkeeping and the resulting commands are handled here.

A request carries a processor number, a read/write flag and a block index. It is accepted with a valid/ready handshake, and requests are handled one at a time. In the cycle after acceptance the block drives the invalidate vector and any writeback request. In the cycle after that it returns a grant to the requester, together with the updated sharer set and dirty flag of that block. An elaboration parameter selects how sharers are stored. The full-map form keeps one presence bit per processor. The limited form keeps two 3-bit processor pointers, each with its own valid bit. When both pointers are in use and a third processor reads, the processor held in pointer 0 is invalidated and its slot is given to the new reader.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every block's entry is empty and clean. req_ready is 1, and inv_valid, wb_valid and gnt_valid are 0. The first read of any block grants a sharer set holding only the requester, with no invalidate and no writeback.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is then 0 in the issue cycle and in the grant cycle, and it returns to 1 in the cycle after the grant.
- R3: A read adds the requester to the block's sharers. Bit i of ent_sharers stands for processor i. A read never raises inv_valid in full-map mode. A read by a processor that is already recorded changes nothing.
- R4: A write raises inv_valid, in the issue cycle, with inv_vec holding every other recorded holder. inv_valid stays 0 when there are no other holders, and inv_vec never includes the writer. After the write the entry shows only the writer, with ent_dirty set to 1.
- R5: A read by processor p of a dirty block owned by some other processor q raises wb_valid with wb_pid = q in the issue cycle. The granted entry then has ent_dirty = 0 and keeps q as a sharer. A read by the owner itself raises no writeback and leaves the block dirty.
- R6: gnt_valid is 1 for exactly one cycle, the cycle right after the issue cycle. In that cycle gnt_pid equals the requester, and ent_sharers and ent_dirty show the block's updated entry.
- R7: In limited mode no more than two sharers are ever recorded. A read by a new processor while both pointers are valid invalidates the pointer-0 holder and records the requester in its place; the pointer-1 holder stays.
- R8: In limited mode a new reader takes pointer 0 if it is free, otherwise pointer 1. A write leaves the writer alone in pointer 0.
- R9: Each block's entry is independent. A request to one block does not change the entry of any other block.
- R10: In full-map mode any number of processors, up to all eight, can be recorded as sharers of one block at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_pid | input | 3 | Requesting processor number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_blk | input | 4 | Block index |
| inv_valid | output | 1 | Invalidate command valid (issue cycle) |
| inv_vec | output | 8 | Processors that must drop their copy |
| wb_valid | output | 1 | Writeback request to the dirty owner (issue cycle) |
| wb_pid | output | 3 | Processor asked to write back |
| gnt_valid | output | 1 | Grant to the requester |
| gnt_pid | output | 3 | Processor being granted |
| ent_sharers | output | 8 | Updated sharer set of the block, one bit per processor |
| ent_dirty | output | 1 | Updated dirty flag of the block |

## Verification
The bench builds two copies of the block side by side, both with 8 processors and 16 blocks. One uses the full-map setting and the other uses the limited setting, and both receive the same request stream, so each step checks one expected result per encoding. With both settings present, a single sequence reaches both the limited form's pointer-0 eviction and the full-map form's eight-sharer entry. The 16-block depth lets requests to a second block show that blocks do not disturb one another.

// File: rtl/coh_dir_pkg.sv
// Package: shared constants and the controller state type for the
// coherence directory. Assumes processor and block counts are powers of two.
package coh_dir_pkg;

    // One-hot controller state: idle, issue (commands out), grant.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'b001,
        ST_ISSUE = 3'b010,
        ST_GRANT = 3'b100
    } dir_state_e;

    // Width of one stored entry for the chosen sharer encoding.
    function automatic int entry_width(int nproc, bit limited);
        int pw;
        pw = $clog2(nproc);
        if (limited) return 2 * (pw + 1) + 1;
        return nproc + 1;
    endfunction

endpackage

// File: rtl/coh_dir_store.sv
// Directory entry store: one register per block, cleared to all zeros
// by reset. Read is combinational; write happens on the clock edge.
// Assumes NBLK is a power of two so every index is a legal entry.
module coh_dir_store #(
    parameter int NBLK = 16,
    parameter int EW   = 9,
    parameter int BW   = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_idx,
    input  logic [EW-1:0] wr_data,
    input  logic [BW-1:0] rd_idx,
    output logic [EW-1:0] rd_data
);

    logic [EW-1:0] mem [NBLK];

    // Purpose: clear all entries on reset, else write the selected entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Purpose: combinational read port.
    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/coh_dir_update.sv
// Next-entry logic: from the current entry and a request, computes the
// new entry, the invalidate set, any writeback demand and the decoded
// sharer view of the new entry. Purely combinational.
// Full-map layout: {dirty, presence[NPROC-1:0]}.
// Limited layout:  {dirty, v1, p1, v0, p0}; a dirty entry keeps its owner in p0.
module coh_dir_update #(
    parameter int NPROC   = 8,
    parameter bit LIMITED = 1'b0,
    parameter int PW      = $clog2(NPROC),
    parameter int EW      = coh_dir_pkg::entry_width(NPROC, LIMITED)
) (
    input  logic [EW-1:0]    cur,
    input  logic [PW-1:0]    pid,
    input  logic             is_wr,
    output logic [EW-1:0]    nxt,
    output logic [NPROC-1:0] inv_vec,
    output logic             wb_need,
    output logic [PW-1:0]    wb_pid,
    output logic [NPROC-1:0] nxt_sharers,
    output logic             nxt_dirty
);

    logic [NPROC-1:0] req_bit;

    // Purpose: one-hot mask of the requester.
    always_comb begin
        req_bit      = '0;
        req_bit[pid] = 1'b1;
    end

    if (!LIMITED) begin : g_fullmap
        logic [NPROC-1:0] pres;
        logic             dirty;
        logic [PW-1:0]    owner;
        logic [NPROC-1:0] n_pres;

        assign pres  = cur[NPROC-1:0];
        assign dirty = cur[NPROC];

        // Purpose: lowest set presence bit names the owner of a dirty block.
        always_comb begin
            owner = '0;
            for (int i = NPROC - 1; i >= 0; i--) begin
                if (pres[i]) owner = PW'(i);
            end
        end

        // Purpose: apply read or write rules to the presence vector.
        always_comb begin
            if (is_wr) begin
                inv_vec   = pres & ~req_bit;
                wb_need   = 1'b0;
                n_pres    = req_bit;
                nxt_dirty = 1'b1;
            end else begin
                inv_vec   = '0;
                wb_need   = dirty && (owner != pid);
                n_pres    = pres | req_bit;
                nxt_dirty = dirty && !(dirty && (owner != pid));
            end
        end

        assign wb_pid      = owner;
        assign nxt         = {nxt_dirty, n_pres};
        assign nxt_sharers = n_pres;
    end else begin : g_limited
        logic [PW-1:0] p0, p1, n_p0, n_p1;
        logic          v0, v1, n_v0, n_v1;
        logic          dirty;
        logic          hit;

        assign p0    = cur[PW-1:0];
        assign v0    = cur[PW];
        assign p1    = cur[2*PW:PW+1];
        assign v1    = cur[2*PW+1];
        assign dirty = cur[2*PW+2];
        assign hit   = (v0 && p0 == pid) || (v1 && p1 == pid);

        // Purpose: turn a pointer and its valid bit into a processor mask.
        function automatic logic [NPROC-1:0] ptr_mask(logic v, logic [PW-1:0] p);
            logic [NPROC-1:0] m;
            m = '0;
            if (v) m[p] = 1'b1;
            return m;
        endfunction

        // Purpose: apply read or write rules, with pointer-0 eviction when full.
        always_comb begin
            n_p0      = p0;
            n_v0      = v0;
            n_p1      = p1;
            n_v1      = v1;
            inv_vec   = '0;
            wb_need   = 1'b0;
            nxt_dirty = dirty;
            if (is_wr) begin
                inv_vec   = (ptr_mask(v0, p0) | ptr_mask(v1, p1)) & ~req_bit;
                n_p0      = pid;
                n_v0      = 1'b1;
                n_p1      = '0;
                n_v1      = 1'b0;
                nxt_dirty = 1'b1;
            end else begin
                wb_need = dirty && v0 && (p0 != pid);
                if (wb_need) nxt_dirty = 1'b0;
                if (!hit) begin
                    if (!v0) begin
                        n_p0 = pid;
                        n_v0 = 1'b1;
                    end else if (!v1) begin
                        n_p1 = pid;
                        n_v1 = 1'b1;
                    end else begin
                        inv_vec = ptr_mask(1'b1, p0);
                        n_p0    = pid;
                    end
                end
            end
        end

        assign wb_pid      = p0;
        assign nxt         = {nxt_dirty, n_v1, n_p1, n_v0, n_p0};
        assign nxt_sharers = ptr_mask(n_v0, n_p0) | ptr_mask(n_v1, n_p1);
    end

endmodule

// File: rtl/coh_dir_ctrl.sv
// Centralized coherence directory controller (top). Takes one request at
// a time over valid/ready, drives invalidate and writeback commands in the
// issue cycle, writes back the updated entry, and grants in the next cycle.
// Assumes the requester keeps no other request outstanding until granted.
module coh_dir_ctrl #(
    parameter int NPROC   = 8,
    parameter int NBLK    = 16,
    parameter bit LIMITED = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [$clog2(NPROC)-1:0]  req_pid,
    input  logic                      req_write,
    input  logic [$clog2(NBLK)-1:0]   req_blk,
    output logic                      inv_valid,
    output logic [NPROC-1:0]          inv_vec,
    output logic                      wb_valid,
    output logic [$clog2(NPROC)-1:0]  wb_pid,
    output logic                      gnt_valid,
    output logic [$clog2(NPROC)-1:0]  gnt_pid,
    output logic [NPROC-1:0]          ent_sharers,
    output logic                      ent_dirty
);
    import coh_dir_pkg::*;

    localparam int PW = $clog2(NPROC);
    localparam int BW = $clog2(NBLK);
    localparam int EW = entry_width(NPROC, LIMITED);

    dir_state_e       state;
    logic [PW-1:0]    pid_q;
    logic             wr_q;
    logic [BW-1:0]    blk_q;
    logic [NPROC-1:0] sh_q;
    logic             dirty_q;

    logic [EW-1:0]    cur_ent, nxt_ent;
    logic [NPROC-1:0] inv_c, nxt_sh;
    logic             wb_c, nxt_d;
    logic [PW-1:0]    wbpid_c;
    logic             issuing;

    assign issuing = (state == ST_ISSUE);

    coh_dir_store #(.NBLK(NBLK), .EW(EW), .BW(BW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (issuing),
        .wr_idx  (blk_q),
        .wr_data (nxt_ent),
        .rd_idx  (blk_q),
        .rd_data (cur_ent)
    );

    coh_dir_update #(.NPROC(NPROC), .LIMITED(LIMITED), .PW(PW), .EW(EW)) u_update (
        .cur         (cur_ent),
        .pid         (pid_q),
        .is_wr       (wr_q),
        .nxt         (nxt_ent),
        .inv_vec     (inv_c),
        .wb_need     (wb_c),
        .wb_pid      (wbpid_c),
        .nxt_sharers (nxt_sh),
        .nxt_dirty   (nxt_d)
    );

    // Purpose: request sequencing and capture of the granted entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pid_q   <= '0;
            wr_q    <= 1'b0;
            blk_q   <= '0;
            sh_q    <= '0;
            dirty_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        pid_q <= req_pid;
                        wr_q  <= req_write;
                        blk_q <= req_blk;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    sh_q    <= nxt_sh;
                    dirty_q <= nxt_d;
                    state   <= ST_GRANT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive handshake, command and grant outputs from the state.
    assign req_ready   = (state == ST_IDLE);
    assign inv_valid   = issuing && (|inv_c);
    assign inv_vec     = issuing ? inv_c : '0;
    assign wb_valid    = issuing && wb_c;
    assign wb_pid      = wbpid_c;
    assign gnt_valid   = (state == ST_GRANT);
    assign gnt_pid     = pid_q;
    assign ent_sharers = sh_q;
    assign ent_dirty   = dirty_q;

    // ---------------- assertions ----------------
    assert_state_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !gnt_valid));

    assert_grant_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready, 2) |-> (gnt_valid && !req_ready));

    assert_grant_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> (!gnt_valid && req_ready));

    assert_no_self_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !inv_vec[pid_q]);

    assert_write_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && wr_q) |-> (ent_dirty && $countones(ent_sharers) == 1 && ent_sharers[pid_q]));

    assert_read_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !wr_q) |-> ent_sharers[pid_q]);

    assert_wb_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (gnt_valid && !ent_dirty && ent_sharers[$past(wb_pid)]));

    if (LIMITED) begin : g_lim_chk
        assert_two_ptrs_R7: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid |-> ($countones(ent_sharers) <= 2));
    end

endmodule

// File: tb/tb_coh_dir_ctrl.sv
`timescale 1ns/1ps
module tb_coh_dir_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_pid = '0;
    logic       req_write = 1'b0;
    logic [3:0] req_blk = '0;

    logic       f_rdy, f_iv, f_wbv, f_gv, f_d;
    logic [7:0] f_inv, f_sh;
    logic [2:0] f_wbp, f_gp;
    logic       l_rdy, l_iv, l_wbv, l_gv, l_d;
    logic [7:0] l_inv, l_sh;
    logic [2:0] l_wbp, l_gp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    coh_dir_ctrl #(.NPROC(8), .NBLK(16), .LIMITED(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(f_rdy),
        .req_pid(req_pid), .req_write(req_write), .req_blk(req_blk),
        .inv_valid(f_iv), .inv_vec(f_inv), .wb_valid(f_wbv), .wb_pid(f_wbp),
        .gnt_valid(f_gv), .gnt_pid(f_gp), .ent_sharers(f_sh), .ent_dirty(f_d));

    coh_dir_ctrl #(.NPROC(8), .NBLK(16), .LIMITED(1'b1)) dut_lim (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(l_rdy),
        .req_pid(req_pid), .req_write(req_write), .req_blk(req_blk),
        .inv_valid(l_iv), .inv_vec(l_inv), .wb_valid(l_wbv), .wb_pid(l_wbp),
        .gnt_valid(l_gv), .gnt_pid(l_gp), .ent_sharers(l_sh), .ent_dirty(l_d));

    // Observed results of one request (issue cycle and grant cycle).
    logic [7:0] o_finv, o_fsh, o_linv, o_lsh;
    logic       o_fwb, o_lwb, o_fd, o_ld;
    logic [2:0] o_fwbp, o_lwbp;

    typedef struct packed {
        logic [2:0] pid;
        logic       wr;
        logic [3:0] blk;
        logic [7:0] f_inv;
        logic [7:0] f_sh;
        logic [7:0] l_inv;
        logic [7:0] l_sh;
        logic       dirty;
        logic       wb;
        logic [2:0] wb_pid;
    } vec_t;

    // One block-3 history plus block-9 steps (R3, R4, R5, R7, R8, R9).
    localparam vec_t VEC [12] = '{
        '{3'd0, 1'b0, 4'd3, 8'h00, 8'h01, 8'h00, 8'h01, 1'b0, 1'b0, 3'd0},
        '{3'd5, 1'b0, 4'd3, 8'h00, 8'h21, 8'h00, 8'h21, 1'b0, 1'b0, 3'd0},
        '{3'd0, 1'b1, 4'd3, 8'h20, 8'h01, 8'h20, 8'h01, 1'b1, 1'b0, 3'd0},
        '{3'd3, 1'b0, 4'd3, 8'h00, 8'h09, 8'h00, 8'h09, 1'b0, 1'b1, 3'd0},
        '{3'd6, 1'b0, 4'd3, 8'h00, 8'h49, 8'h01, 8'h48, 1'b0, 1'b0, 3'd0},
        '{3'd3, 1'b0, 4'd3, 8'h00, 8'h49, 8'h00, 8'h48, 1'b0, 1'b0, 3'd0},
        '{3'd7, 1'b1, 4'd3, 8'h49, 8'h80, 8'h48, 8'h80, 1'b1, 1'b0, 3'd0},
        '{3'd7, 1'b0, 4'd3, 8'h00, 8'h80, 8'h00, 8'h80, 1'b1, 1'b0, 3'd0},
        '{3'd2, 1'b1, 4'd3, 8'h80, 8'h04, 8'h80, 8'h04, 1'b1, 1'b0, 3'd0},
        '{3'd1, 1'b0, 4'd9, 8'h00, 8'h02, 8'h00, 8'h02, 1'b0, 1'b0, 3'd0},
        '{3'd4, 1'b0, 4'd3, 8'h00, 8'h14, 8'h00, 8'h14, 1'b0, 1'b1, 3'd2},
        '{3'd1, 1'b1, 4'd9, 8'h00, 8'h02, 8'h00, 8'h02, 1'b1, 1'b0, 3'd0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one request and capture both instances; checks R2/R6 timing.
    task automatic run_req(input logic [2:0] pid, input logic wr, input logic [3:0] blk);
        @(negedge clk);
        chk("R2", "ready before request", {30'd0, f_rdy, l_rdy}, 32'h3);
        req_valid = 1'b1; req_pid = pid; req_write = wr; req_blk = blk;
        @(posedge clk); #1;
        o_finv = f_iv ? f_inv : 8'h00;
        o_linv = l_iv ? l_inv : 8'h00;
        if (f_iv && f_inv == 8'h00) chk("R4", "inv_valid with empty vector", 1, 0);
        o_fwb = f_wbv; o_fwbp = f_wbp;
        o_lwb = l_wbv; o_lwbp = l_wbp;
        chk("R2", "busy in issue cycle", {28'd0, f_rdy, l_rdy, f_gv, l_gv}, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R6", "grant cycle", {24'd0, f_gv, l_gv, f_rdy, l_rdy, 1'b0, 3'd0}, {24'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0});
        chk("R6", "gnt_pid", {26'd0, f_gp, l_gp}, {26'd0, pid, pid});
        o_fsh = f_sh; o_fd = f_d;
        o_lsh = l_sh; o_ld = l_d;
        @(posedge clk); #1;
        chk("R2", "ready after grant", {29'd0, f_rdy, l_rdy, f_gv}, {29'd0, 1'b1, 1'b1, 1'b0});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "outputs in reset", {26'd0, f_rdy, l_rdy, f_iv | l_iv, f_wbv | l_wbv, f_gv | l_gv, 1'b0},
            {26'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();

        // Table walk covering read, write, writeback and eviction rules.
        for (int i = 0; i < 12; i++) begin
            run_req(VEC[i].pid, VEC[i].wr, VEC[i].blk);
            chk("R4", $sformatf("step %0d full inv", i), {24'd0, o_finv}, {24'd0, VEC[i].f_inv});
            chk("R7", $sformatf("step %0d lim inv", i), {24'd0, o_linv}, {24'd0, VEC[i].l_inv});
            chk("R3", $sformatf("step %0d full sharers", i), {24'd0, o_fsh}, {24'd0, VEC[i].f_sh});
            chk("R8", $sformatf("step %0d lim sharers", i), {24'd0, o_lsh}, {24'd0, VEC[i].l_sh});
            chk("R5", $sformatf("step %0d dirty", i), {30'd0, o_fd, o_ld}, {30'd0, VEC[i].dirty, VEC[i].dirty});
            chk("R5", $sformatf("step %0d wb", i), {30'd0, o_fwb, o_lwb}, {30'd0, VEC[i].wb, VEC[i].wb});
            if (VEC[i].wb)
                chk("R5", $sformatf("step %0d wb_pid", i), {26'd0, o_fwbp, o_lwbp}, {26'd0, VEC[i].wb_pid, VEC[i].wb_pid});
        end

        // R10 / R7: eight readers of block 5.
        for (int p = 0; p < 8; p++) begin
            run_req(3'(p), 1'b0, 4'd5);
            if (p == 2) chk("R7", "third reader evicts pointer 0", {24'd0, o_linv}, 32'h01);
        end
        chk("R10", "full-map eight sharers", {24'd0, o_fsh}, 32'hFF);
        chk("R7", "limited keeps two sharers", {24'd0, o_lsh}, 32'h82);
        chk("R7", "last eviction targets P6", {24'd0, o_linv}, 32'h40);
        chk("R3", "full-map read no inv", {24'd0, o_finv}, 32'h00);

        // R4: write by P0 to the crowded block.
        run_req(3'd0, 1'b1, 4'd5);
        chk("R4", "full-map write inv all others", {24'd0, o_finv}, 32'hFE);
        chk("R4", "limited write inv both pointers", {24'd0, o_linv}, 32'h82);
        chk("R4", "writer alone dirty", {15'd0, o_fsh, o_lsh, o_fd, o_ld}, {15'd0, 8'h01, 8'h01, 1'b1, 1'b1});

        // R9: block 9 untouched by block 5 traffic; P1 rereads its dirty block.
        run_req(3'd1, 1'b0, 4'd9);
        chk("R9", "block 9 unchanged", {14'd0, o_fsh, o_lsh, o_fd, o_ld, o_fwb, o_lwb},
            {14'd0, 8'h02, 8'h02, 1'b1, 1'b1, 1'b0, 1'b0});

        // R1: a mid-run reset clears every entry.
        do_reset();
        run_req(3'd0, 1'b0, 4'd3);
        chk("R1", "block 3 empty after reset", {12'd0, o_fsh, o_lsh, o_fd, o_ld, o_fwb, o_lwb, o_finv == 0, o_linv == 0},
            {12'd0, 8'h01, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
        run_req(3'd6, 1'b0, 4'd5);
        chk("R1", "block 5 empty after reset", {16'd0, o_fsh, o_lsh}, {16'd0, 8'h40, 8'h40});

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule